// File: doc/BRIEF.md
# Dual-Mode Edge-Kicked Watchdog

This block watches a processor's kick line and pulls an active-low fault output low when software stops toggling it. A kick is any change of level on the line, rising or falling. After each system reset the block first grants a long boot window, so that software can finish starting up. The window is a fixed multiple of the normal period. Once the first kick arrives, or once the long window runs out, the block switches to the short normal period. A status output reports which of the two periods is in force.

The block sits beside a reset sequencer. While system reset, manual reset or undervoltage is active, the counter is held clear. Counting starts again in long mode on the one-cycle release pulse that the sequencer gives when its reset timeout ends. Undervoltage forces the fault output low. Manual reset, and recovery of every supply, release the fault output at once.

A build-time option loops the fault back as a manual reset. A timeout then clears itself after one cycle and waits for the next release pulse. Both periods are counted in prescaler ticks, and each tick is `PRESCALE` clock cycles long.

Top module: `wdg_dualmode`

## Requirements
- R1: While `rst_n` is low, and after it rises until a release pulse is seen, `wdo_n` is 1 and `long_mode` is 1.
- R2: A kick is a rising or a falling edge of `kick_in`, taken after a two-flop synchronizer. A level change of `kick_in` that is stable before clock edge k is acted on at edge k+2. A kick restarts the period count.
- R3: After a release pulse with no kick, the fault is raised `SHORT_TICKS*LONG_MULT*PRESCALE` cycles after the edge that sampled the pulse. At the same edge `long_mode` drops to 0.
- R4: The first kick after a release sets `long_mode` to 0. From then on the fault is raised `SHORT_TICKS*PRESCALE` cycles after the last kick.
- R5: Without loopback, a raised fault holds `wdo_n` low and stops the count until the next kick. That kick deasserts the fault and starts a short period.
- R6: While `sys_rst` or `mr_req` is 1, the count is cleared, the fault deasserts at the next edge, and `long_mode` is 1. Counting stays stopped until a release pulse arrives with no hold condition present.
- R7: While `uv_flag` is 1, `wdo_n` is 0 in the same cycle, with no clock edge needed. The count is also held clear, as in R6.
- R8: Kicks that arrive while the count is stopped (held or not yet released) have no effect on `wdo_n` or `long_mode`.
- R9: With `LOOPBACK=1`, a timeout drives `wdo_n` low for exactly one cycle. The fault then acts as a manual reset, and counting stops until the next release pulse.
- R10: A release pulse that coincides with `sys_rst`, `mr_req` or `uv_flag` does not start counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| kick_in | input | 1 | Asynchronous kick line from the processor |
| sys_rst | input | 1 | System reset is being asserted (active high) |
| rst_release | input | 1 | One-cycle pulse: the reset timeout has ended |
| mr_req | input | 1 | Manual reset request (active high) |
| uv_flag | input | 1 | Undervoltage present on any monitored supply (active high) |
| wdo_n | output | 1 | Active-low watchdog fault |
| long_mode | output | 1 | 1 while the long boot period is in force |

## Verification
The bench aims at the exact expiry cycle of the long window and of the short window. An off-by-one counter, or a prescaler that slips by a cycle, would move the fault edge and show up as a mismatch at that cycle. It drives falling kicks as well as rising ones, so a detector that sees only rising edges would time out early. It sends kicks and release pulses while a hold is active; a design that let them through would start counting or leave boot mode by mistake. A second instance with loopback checks the one-cycle fault pulse, which would stick or repeat if the fault were not fed back as a reset.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  // Number of prescaler ticks in the active period.
  function automatic int unsigned period_ticks(input logic long_sel,
                                               input int unsigned short_t,
                                               input int unsigned mult);
    return long_sel ? short_t * mult : short_t;
  endfunction
endpackage

// File: rtl/wdg_kick_sync.sv
module wdg_kick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic kick_edge
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh[0] <= 1'b0;
    else        sh[0] <= din;
  end

  for (genvar g = 1; g <= STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh[g] <= 1'b0;
      else        sh[g] <= sh[g-1];
    end
  end

  assign kick_edge = sh[STAGES-1] ^ sh[STAGES];
endmodule

// File: rtl/wdg_tick_gen.sv
module wdg_tick_gen #(
  parameter int PRESCALE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic tick
);
  localparam int PW = $clog2(PRESCALE + 1);
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] pre;

  assign tick = en && (pre == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pre <= '0;
    else if (clr)   pre <= '0;
    else if (en)    pre <= (pre == LAST) ? '0 : pre + 1'b1;
  end

  // R3
  pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre <= LAST);
endmodule

// File: rtl/wdg_period_ctr.sv
module wdg_period_ctr
  import wdg_pkg::*;
#(
  parameter int SHORT_TICKS = 5,
  parameter int LONG_MULT   = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic release_p,
  input  logic kick_edge,
  input  logic tick,
  output logic armed_q,
  output logic long_q,
  output logic fault_q,
  output logic tick_clr,
  output logic tick_en
);
  localparam int CW = $clog2(SHORT_TICKS * LONG_MULT + 1);

  logic [CW-1:0] cnt;
  logic          expire;
  logic          kick_take;

  assign kick_take = armed_q && !hold && !release_p && kick_edge;
  assign tick_clr  = hold || release_p || kick_take;
  assign tick_en   = armed_q && !fault_q && !tick_clr;
  assign expire    = tick &&
    (cnt == CW'(period_ticks(long_q, SHORT_TICKS, LONG_MULT) - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0; long_q <= 1'b1; fault_q <= 1'b0; cnt <= '0;
    end else if (hold) begin
      armed_q <= 1'b0; long_q <= 1'b1; fault_q <= 1'b0; cnt <= '0;
    end else if (release_p) begin
      armed_q <= 1'b1; long_q <= 1'b1; fault_q <= 1'b0; cnt <= '0;
    end else if (kick_take) begin
      long_q <= 1'b0; fault_q <= 1'b0; cnt <= '0;
    end else if (expire) begin
      long_q <= 1'b0; fault_q <= 1'b1; cnt <= '0;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R6
  hold_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (!fault_q && long_q && !armed_q));
  // R3
  fault_in_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_q) |-> !long_q);
  // R8
  fault_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_q) |-> $past(armed_q));
  // R4
  kick_to_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick_take |=> (!long_q && !fault_q));
  // R10
  release_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (release_p && hold) |=> !armed_q);
endmodule

// File: rtl/wdg_dualmode.sv
module wdg_dualmode #(
  parameter int PRESCALE    = 4,
  parameter int SHORT_TICKS = 5,
  parameter int LONG_MULT   = 32,
  parameter int SYNC_STAGES = 2,
  parameter bit LOOPBACK    = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_in,
  input  logic sys_rst,
  input  logic rst_release,
  input  logic mr_req,
  input  logic uv_flag,
  output logic wdo_n,
  output logic long_mode
);
  logic kick_edge, tick, tick_clr, tick_en;
  logic armed_q, long_q, fault_q;
  logic mr_eff, hold;

  if (LOOPBACK) begin : g_loop
    assign mr_eff = mr_req || fault_q;
  end else begin : g_noloop
    assign mr_eff = mr_req;
  end

  assign hold      = sys_rst || mr_eff || uv_flag;
  assign wdo_n     = !(fault_q || uv_flag);
  assign long_mode = long_q;

  wdg_kick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(kick_in), .kick_edge(kick_edge));

  wdg_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(tick_clr), .en(tick_en), .tick(tick));

  wdg_period_ctr #(.SHORT_TICKS(SHORT_TICKS), .LONG_MULT(LONG_MULT)) u_ctr (
    .clk(clk), .rst_n(rst_n), .hold(hold), .release_p(rst_release),
    .kick_edge(kick_edge), .tick(tick), .armed_q(armed_q), .long_q(long_q),
    .fault_q(fault_q), .tick_clr(tick_clr), .tick_en(tick_en));

  // R7
  uv_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uv_flag |-> !wdo_n);

  if (LOOPBACK) begin : g_loop_chk
    // R9
    loop_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_q |=> !fault_q);
  end
endmodule

// File: tb/wdg_dualmode_bench.sv
module wdg_dualmode_bench;
  localparam int PS = 4, ST = 5, LM = 32;
  localparam int SHORT_C = ST * PS;
  localparam int LONG_C  = ST * LM * PS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic kick_in = 1'b0, sys_rst = 1'b1, rst_release = 1'b0;
  logic mr_req = 1'b0, uv_flag = 1'b0;
  logic wdo_n [2];
  logic long_mode [2];

  int compared = 0, mismatched = 0, cycles = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  wdg_dualmode #(.PRESCALE(PS), .SHORT_TICKS(ST), .LONG_MULT(LM)) u_wdg_dualmode (
    .clk(clk), .rst_n(rst_n), .kick_in(kick_in), .sys_rst(sys_rst),
    .rst_release(rst_release), .mr_req(mr_req), .uv_flag(uv_flag),
    .wdo_n(wdo_n[0]), .long_mode(long_mode[0]));

  wdg_dualmode #(.PRESCALE(PS), .SHORT_TICKS(ST), .LONG_MULT(LM), .LOOPBACK(1'b1))
    u_wdg_dualmode_loop (
    .clk(clk), .rst_n(rst_n), .kick_in(kick_in), .sys_rst(sys_rst),
    .rst_release(rst_release), .mr_req(mr_req), .uv_flag(uv_flag),
    .wdo_n(wdo_n[1]), .long_mode(long_mode[1]));

  // Behavioural reference: shared kick history, one state set per instance.
  bit kq[$];
  bit m_run [2], m_long [2], m_fault [2];
  int m_elapsed [2];

  initial begin
    kq = {1'b0, 1'b0, 1'b0};
    for (int i = 0; i < 2; i++) begin
      m_run[i] = 0; m_long[i] = 1; m_fault[i] = 0; m_elapsed[i] = 0;
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kq = {1'b0, 1'b0, 1'b0};
      for (int i = 0; i < 2; i++) begin
        m_run[i] = 0; m_long[i] = 1; m_fault[i] = 0; m_elapsed[i] = 0;
      end
    end else begin
      bit saw_kick;
      saw_kick = kq[1] != kq[2];
      kq.push_front(kick_in);
      void'(kq.pop_back());
      for (int i = 0; i < 2; i++) begin
        bit held;
        held = sys_rst || mr_req || uv_flag || (i == 1 && m_fault[i]);
        if (held) begin
          m_run[i] = 0; m_long[i] = 1; m_fault[i] = 0; m_elapsed[i] = 0;
        end else if (rst_release) begin
          m_run[i] = 1; m_long[i] = 1; m_fault[i] = 0; m_elapsed[i] = 0;
        end else if (m_run[i] && saw_kick) begin
          m_long[i] = 0; m_fault[i] = 0; m_elapsed[i] = 0;
        end else if (m_run[i] && !m_fault[i]) begin
          if (m_elapsed[i] == (m_long[i] ? LONG_C : SHORT_C) - 1) begin
            m_fault[i] = 1; m_long[i] = 0; m_elapsed[i] = 0;
          end else m_elapsed[i]++;
        end
      end
    end
  end

  always @(posedge clk) begin
    #2;
    cycles++;
    for (int i = 0; i < 2; i++) begin
      logic exp_w;
      exp_w = !(m_fault[i] || uv_flag);
      compared++;
      if (wdo_n[i] !== exp_w) begin
        mismatched++;
        $display("FAIL %s inst%0d wdo_n actual=%b expected=%b t=%0t",
                 cur_req, i, wdo_n[i], exp_w, $time);
      end
      compared++;
      if (long_mode[i] !== m_long[i]) begin
        mismatched++;
        $display("FAIL %s inst%0d long_mode actual=%b expected=%b t=%0t",
                 cur_req, i, long_mode[i], m_long[i], $time);
      end
    end
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_release();
    rst_release = 1'b1; wait_cyc(1); rst_release = 1'b0;
  endtask

  initial begin
    wait_cyc(4);
    cur_req = "R1";
    compared++;
    if (wdo_n[0] !== 1'b1 || long_mode[0] !== 1'b1) begin
      mismatched++;
      $display("FAIL R1 reset actual=%b%b expected=11", wdo_n[0], long_mode[0]);
    end
    rst_n = 1'b1;
    wait_cyc(5);
    cur_req = "R8";
    for (int k = 0; k < 6; k++) begin kick_in = ~kick_in; wait_cyc(3); end
    sys_rst = 1'b0;
    wait_cyc(10);
    cur_req = "R10";
    mr_req = 1'b1; pulse_release(); mr_req = 1'b0;
    wait_cyc(LONG_C + 20);
    cur_req = "R3";
    pulse_release();
    wait_cyc(LONG_C + 30);
    cur_req = "R5";
    kick_in = ~kick_in;
    wait_cyc(8);
    cur_req = "R2";
    for (int k = 0; k < 6; k++) begin kick_in = ~kick_in; wait_cyc(SHORT_C - 6); end
    cur_req = "R4";
    wait_cyc(SHORT_C + 10);
    cur_req = "R6";
    mr_req = 1'b1; wait_cyc(3); mr_req = 1'b0;
    wait_cyc(5);
    pulse_release();
    cur_req = "R4";
    wait_cyc(30);
    kick_in = ~kick_in;
    wait_cyc(SHORT_C + 10);
    cur_req = "R9";
    pulse_release();
    wait_cyc(LONG_C + 10);
    cur_req = "R7";
    kick_in = ~kick_in; wait_cyc(5);
    uv_flag = 1'b1; wait_cyc(4);
    kick_in = ~kick_in; wait_cyc(4);
    uv_flag = 1'b0; wait_cyc(3);
    pulse_release();
    wait_cyc(7);
    kick_in = ~kick_in; wait_cyc(9);
    cur_req = "R6";
    sys_rst = 1'b1; wait_cyc(6); sys_rst = 1'b0;
    wait_cyc(SHORT_C + 5);
    pulse_release();
    wait_cyc(LONG_C + 10);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule